// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the transmit and receive error counters of a CAN controller and classifies the node as error active, error passive or bus off. The protocol engine sends it single-cycle pulses: a transmit error, a transmit success, a receive error (with a flag that selects the heavy weighting) and a receive success. The block applies the counter arithmetic and publishes the resulting confinement state.

Once the transmit counter reaches the bus-off threshold, the node leaves the bus. The receive counter is then cleared and given a different job. Each bit sampled at the sample point is reported through a tick, together with its level. The receive counter counts complete runs of eleven recessive samples, which is the idle gap between frames. After 128 such runs the node rejoins as error active. Both counters return to zero and a software interrupt flag is raised. The flag stays set until software clears it. Bit timing configuration lives elsewhere and recovery does not touch it.

Top module: `canFaultConfine`

## Requirements
- R1: After reset, both counters read 0, the state reads 00 (error active) and the interrupt flag reads 0.
- R2: Outside bus off, a transmit error adds 8 to the transmit counter. A transmit success subtracts 1, and the counter never goes below 0. When both arrive in the same cycle, the error wins.
- R3: Outside bus off and below 128, a receive error adds 1, or 8 when the heavy flag is set. A receive success subtracts 1 and never goes below 0. A receive error wins over a receive success in the same cycle.
- R4: The state reads 01 (error passive) when either counter is at or above 128 and the node is not bus off. Otherwise, outside bus off, it reads 00.
- R5: While the receive counter is at or above 128, a receive error leaves it unchanged.
- R6: While the receive counter is at or above 128, a receive success loads it with 120.
- R7: A transmit error that brings the transmit counter to 256 or more makes the state read 10 (bus off) after that clock edge. The same edge clears the receive counter.
- R8: While bus off, a bit tick with a recessive level extends the current run. The eleventh consecutive recessive tick adds 1 to the receive counter and starts a new run. A tick with a dominant level restarts the run without changing the receive counter. Cycles without a tick change nothing.
- R9: While bus off, transmit and receive error and success pulses have no effect, and the transmit counter holds its value.
- R10: The edge that completes the 128th run makes the state read 00, sets both counters to 0 and sets the interrupt flag.
- R11: The interrupt flag stays set until the clear input is asserted. If recovery completes in the same cycle as a clear, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErr | input | 1 | Transmit error pulse |
| txOk | input | 1 | Transmit success pulse |
| rxErr | input | 1 | Receive error pulse |
| rxErrHeavy | input | 1 | Selects weight 8 for the current receive error |
| rxOk | input | 1 | Receive success pulse |
| bitTick | input | 1 | One pulse per sampled bus bit |
| bitRecessive | input | 1 | Level of the sampled bit, 1 = recessive |
| irqClr | input | 1 | Clears the software interrupt flag |
| txCount | output | 9 | Transmit error counter |
| rxCount | output | 8 | Receive error counter, or recovery run count while bus off |
| state | output | 2 | 00 active, 01 passive, 10 bus off |
| swIrq | output | 1 | Recovery-complete interrupt flag |

## Verification
Every counter and the bus-off flag are registered, so a wrong update shows up at the ports on the very next sample after the edge that caused it. The exception is the hidden run-length counter. A mistake there stays invisible until the next run boundary, up to eleven ticks later. It then appears as a receive count that moved one tick early or late, or failed to move after a dominant bit. A wrong run count only shows in full at recovery, where the state returns to 00 and the interrupt rises early or late. For that reason the bench checks every tick of the full recovery sequence.

// File: rtl/fcPkg.sv
package fcPkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10
  } fcState_t;

  // control -> datapath update strobes
  typedef struct packed {
    logic txInc;
    logic txDec;
    logic rxInc;
    logic rxHeavy;
    logic rxDec;
    logic rxReload;
    logic enterOff;
    logic runStep;
    logic runClr;
    logic recover;
  } fcStrobe_t;

  // datapath -> control comparison results
  typedef struct packed {
    logic txNextOff;
    logic txZero;
    logic txPassive;
    logic rxPassive;
    logic rxZero;
    logic runFull;
    logic recoverNext;
  } fcFlags_t;

endpackage

// File: rtl/fcDatapath.sv
module fcDatapath
  import fcPkg::*;
#(
  parameter int TX_W         = 9,
  parameter int RX_W         = 8,
  parameter int PASSIVE_LIM  = 128,
  parameter int BUSOFF_LIM   = 256,
  parameter int RUN_LEN      = 11,
  parameter int RECOVER_RUNS = 128,
  parameter int TX_STEP      = 8,
  parameter int RX_HEAVY     = 8,
  parameter int RX_RELOAD    = 120
) (
  input  logic            clk,
  input  logic            rstN,
  input  fcStrobe_t       strobe,
  output fcFlags_t        flags,
  output logic [TX_W-1:0] txCnt,
  output logic [RX_W-1:0] rxCnt
);

  localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  localparam logic [TX_W-1:0] TX_STEP_V  = TX_W'(TX_STEP);
  localparam logic [TX_W-1:0] TX_OFF_V   = TX_W'(BUSOFF_LIM);
  localparam logic [TX_W-1:0] TX_PASS_V  = TX_W'(PASSIVE_LIM);
  localparam logic [TX_W-1:0] TX_ONE_V   = TX_W'(1);
  localparam logic [RX_W-1:0] RX_PASS_V  = RX_W'(PASSIVE_LIM);
  localparam logic [RX_W-1:0] RX_ONE_V   = RX_W'(1);
  localparam logic [RX_W-1:0] RX_HEAVY_V = RX_W'(RX_HEAVY);
  localparam logic [RX_W-1:0] RX_LOAD_V  = RX_W'(RX_RELOAD);
  localparam logic [RX_W-1:0] RX_REC_V   = RX_W'(RECOVER_RUNS - 1);
  localparam logic [RUN_W-1:0] RUN_FULL_V = RUN_W'(RUN_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_ONE_V  = RUN_W'(1);

  logic [RUN_W-1:0] runCnt;
  logic [TX_W-1:0]  txPlus;
  logic [RX_W-1:0]  rxStep;

  assign txPlus = txCnt + TX_STEP_V;
  assign rxStep = strobe.rxHeavy ? RX_HEAVY_V : RX_ONE_V;

  always_comb begin
    flags.txNextOff   = (txPlus >= TX_OFF_V);
    flags.txZero      = (txCnt == '0);
    flags.txPassive   = (txCnt >= TX_PASS_V);
    flags.rxPassive   = (rxCnt >= RX_PASS_V);
    flags.rxZero      = (rxCnt == '0);
    flags.runFull     = (runCnt == RUN_FULL_V);
    flags.recoverNext = (rxCnt == RX_REC_V);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCnt  <= '0;
      rxCnt  <= '0;
      runCnt <= '0;
    end else if (strobe.recover) begin
      txCnt  <= '0;
      rxCnt  <= '0;
      runCnt <= '0;
    end else begin
      if (strobe.txInc)      txCnt <= txPlus;
      else if (strobe.txDec) txCnt <= txCnt - TX_ONE_V;

      if (strobe.enterOff)      rxCnt <= '0;
      else if (strobe.rxReload) rxCnt <= RX_LOAD_V;
      else if (strobe.rxInc)    rxCnt <= rxCnt + rxStep;
      else if (strobe.rxDec)    rxCnt <= rxCnt - RX_ONE_V;

      if (strobe.runClr)       runCnt <= '0;
      else if (strobe.runStep) runCnt <= runCnt + RUN_ONE_V;
    end
  end

endmodule

// File: rtl/fcControl.sv
module fcControl
  import fcPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txErr,
  input  logic      txOk,
  input  logic      rxErr,
  input  logic      rxErrHeavy,
  input  logic      rxOk,
  input  logic      bitTick,
  input  logic      bitRecessive,
  input  logic      irqClr,
  input  fcFlags_t  flags,
  output fcStrobe_t strobe,
  output fcState_t  stateCode,
  output logic      swIrq
);

  logic offQ;

  always_comb begin
    strobe = '0;
    if (!offQ) begin
      if (txErr) begin
        strobe.txInc = 1'b1;
        if (flags.txNextOff) begin
          strobe.enterOff = 1'b1;
          strobe.runClr   = 1'b1;
        end
      end else if (txOk && !flags.txZero) begin
        strobe.txDec = 1'b1;
      end

      if (rxErr) begin
        if (!flags.rxPassive) begin
          strobe.rxInc   = 1'b1;
          strobe.rxHeavy = rxErrHeavy;
        end
      end else if (rxOk) begin
        if (flags.rxPassive)   strobe.rxReload = 1'b1;
        else if (!flags.rxZero) strobe.rxDec   = 1'b1;
      end
    end else if (bitTick) begin
      if (!bitRecessive) begin
        strobe.runClr = 1'b1;
      end else if (flags.runFull) begin
        strobe.runClr = 1'b1;
        if (flags.recoverNext) strobe.recover = 1'b1;
        else                   strobe.rxInc   = 1'b1;
      end else begin
        strobe.runStep = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ  <= 1'b0;
      swIrq <= 1'b0;
    end else begin
      if (strobe.enterOff)     offQ <= 1'b1;
      else if (strobe.recover) offQ <= 1'b0;

      if (strobe.recover)  swIrq <= 1'b1;
      else if (irqClr)     swIrq <= 1'b0;
    end
  end

  always_comb begin
    if (offQ)                                  stateCode = ST_BUSOFF;
    else if (flags.txPassive || flags.rxPassive) stateCode = ST_PASSIVE;
    else                                       stateCode = ST_ACTIVE;
  end

endmodule

// File: rtl/canFaultConfine.sv
module canFaultConfine
  import fcPkg::*;
#(
  parameter int TX_W         = 9,
  parameter int RX_W         = 8,
  parameter int PASSIVE_LIM  = 128,
  parameter int BUSOFF_LIM   = 256,
  parameter int RUN_LEN      = 11,
  parameter int RECOVER_RUNS = 128,
  parameter int TX_STEP      = 8,
  parameter int RX_HEAVY     = 8,
  parameter int RX_RELOAD    = 120
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txErr,
  input  logic            txOk,
  input  logic            rxErr,
  input  logic            rxErrHeavy,
  input  logic            rxOk,
  input  logic            bitTick,
  input  logic            bitRecessive,
  input  logic            irqClr,
  output logic [TX_W-1:0] txCount,
  output logic [RX_W-1:0] rxCount,
  output logic [1:0]      state,
  output logic            swIrq
);

  fcStrobe_t strobeW;
  fcFlags_t  flagsW;
  fcState_t  stateW;

  fcControl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .txErr        (txErr),
    .txOk         (txOk),
    .rxErr        (rxErr),
    .rxErrHeavy   (rxErrHeavy),
    .rxOk         (rxOk),
    .bitTick      (bitTick),
    .bitRecessive (bitRecessive),
    .irqClr       (irqClr),
    .flags        (flagsW),
    .strobe       (strobeW),
    .stateCode    (stateW),
    .swIrq        (swIrq)
  );

  fcDatapath #(
    .TX_W         (TX_W),
    .RX_W         (RX_W),
    .PASSIVE_LIM  (PASSIVE_LIM),
    .BUSOFF_LIM   (BUSOFF_LIM),
    .RUN_LEN      (RUN_LEN),
    .RECOVER_RUNS (RECOVER_RUNS),
    .TX_STEP      (TX_STEP),
    .RX_HEAVY     (RX_HEAVY),
    .RX_RELOAD    (RX_RELOAD)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobeW),
    .flags  (flagsW),
    .txCnt  (txCount),
    .rxCnt  (rxCount)
  );

  assign state = stateW;

endmodule

// File: rtl/fcChecker.sv
module fcChecker #(
  parameter int TX_W        = 9,
  parameter int RX_W        = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int TX_STEP     = 8,
  parameter int RX_RELOAD   = 120
) (
  input logic            clk,
  input logic            rstN,
  input logic            txErr,
  input logic            rxErr,
  input logic            rxOk,
  input logic            bitTick,
  input logic            irqClr,
  input logic [TX_W-1:0] txCount,
  input logic [RX_W-1:0] rxCount,
  input logic [1:0]      state,
  input logic            swIrq
);

  localparam logic [TX_W-1:0] STEP_V  = TX_W'(TX_STEP);
  localparam logic [TX_W-1:0] SAFE_V  = TX_W'(BUSOFF_LIM - TX_STEP);
  localparam logic [RX_W-1:0] PASS_V  = RX_W'(PASSIVE_LIM);
  localparam logic [RX_W-1:0] LOAD_V  = RX_W'(RX_RELOAD);

  logic offEntry;
  assign offEntry = txErr && (txCount >= SAFE_V);

  // R2
  tx_err_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != 2'b10 && txErr && txCount < SAFE_V) |=> txCount == $past(txCount) + STEP_V);

  // R5
  rx_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != 2'b10 && rxCount >= PASS_V && rxErr && !offEntry) |=> $stable(rxCount));

  // R6
  rx_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != 2'b10 && rxCount >= PASS_V && rxOk && !rxErr && !offEntry) |=> rxCount == LOAD_V);

  // R7
  busoff_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == 2'b10) |-> rxCount == '0);

  // R9
  busoff_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'b10 && !bitTick) |=> (state == 2'b10 && $stable(txCount) && $stable(rxCount)));

  // R10
  recover_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swIrq) |-> (state == 2'b00 && txCount == '0 && rxCount == '0));

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swIrq && !irqClr) |=> swIrq);

endmodule

bind canFaultConfine fcChecker #(
  .TX_W        (TX_W),
  .RX_W        (RX_W),
  .PASSIVE_LIM (PASSIVE_LIM),
  .BUSOFF_LIM  (BUSOFF_LIM),
  .TX_STEP     (TX_STEP),
  .RX_RELOAD   (RX_RELOAD)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .txErr   (txErr),
  .rxErr   (rxErr),
  .rxOk    (rxOk),
  .bitTick (bitTick),
  .irqClr  (irqClr),
  .txCount (txCount),
  .rxCount (rxCount),
  .state   (state),
  .swIrq   (swIrq)
);

// File: tb/canFaultConfine_tb.sv
`timescale 1ns/1ps
module canFaultConfine_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txErr = 0, txOk = 0, rxErr = 0, rxErrHeavy = 0, rxOk = 0;
  logic bitTick = 0, bitRecessive = 0, irqClr = 0;
  logic [8:0] txCount;
  logic [7:0] rxCount;
  logic [1:0] state;
  logic       swIrq;

  always #2 clk = ~clk;

  canFaultConfine u_dut (
    .clk(clk), .rstN(rstN), .txErr(txErr), .txOk(txOk), .rxErr(rxErr),
    .rxErrHeavy(rxErrHeavy), .rxOk(rxOk), .bitTick(bitTick),
    .bitRecessive(bitRecessive), .irqClr(irqClr), .txCount(txCount),
    .rxCount(rxCount), .state(state), .swIrq(swIrq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // scoreboard queues
  int    qTx[$];
  int    qRx[$];
  int    qSt[$];
  int    qIrq[$];
  string qTag[$];

  // reference model state
  int mTx = 0, mRx = 0, mRun = 0;
  bit mOff = 0, mIrq = 0;

  function automatic int modelState();
    if (mOff) return 2;
    if (mTx >= 128 || mRx >= 128) return 1;
    return 0;
  endfunction

  task automatic step(input bit te, input bit to, input bit re, input bit rh,
                      input bit ro, input bit bt, input bit br, input bit clr,
                      input string tag);
    @(negedge clk);
    txErr = te; txOk = to; rxErr = re; rxErrHeavy = rh; rxOk = ro;
    bitTick = bt; bitRecessive = br; irqClr = clr;
    if (clr) mIrq = 0;
    if (!mOff) begin
      if (te) mTx = mTx + 8;
      else if (to && mTx > 0) mTx = mTx - 1;
      if (mTx >= 256) begin
        mOff = 1; mRx = 0; mRun = 0;
      end else if (re) begin
        if (mRx < 128) mRx = mRx + (rh ? 8 : 1);
      end else if (ro) begin
        if (mRx >= 128) mRx = 120;
        else if (mRx > 0) mRx = mRx - 1;
      end
    end else if (bt) begin
      if (!br) mRun = 0;
      else if (mRun == 10) begin
        mRun = 0;
        if (mRx == 127) begin
          mOff = 0; mTx = 0; mRx = 0; mIrq = 1;
        end else mRx = mRx + 1;
      end else mRun = mRun + 1;
    end
    @(posedge clk);
    #1;
    qTx.push_back(mTx); qRx.push_back(mRx); qSt.push_back(modelState());
    qIrq.push_back(int'(mIrq)); qTag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (qTx.size() > 0) begin
        int eTx, eRx, eSt, eIrq;
        string t;
        eTx = qTx.pop_front(); eRx = qRx.pop_front(); eSt = qSt.pop_front();
        eIrq = qIrq.pop_front(); t = qTag.pop_front();
        checks++;
        if (int'(txCount) != eTx || int'(rxCount) != eRx ||
            int'(state) != eSt || int'(swIrq) != eIrq) begin
          errors++;
          $display("FAIL %s: tx=%0d rx=%0d st=%0d irq=%0d expected tx=%0d rx=%0d st=%0d irq=%0d",
                   t, txCount, rxCount, state, swIrq, eTx, eRx, eSt, eIrq);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (txCount != 0 || rxCount != 0 || state != 2'b00 || swIrq != 1'b0) begin
      errors++;
      $display("FAIL R1: tx=%0d rx=%0d st=%0d irq=%0d expected 0 0 0 0",
               txCount, rxCount, state, swIrq);
    end

    // R3 receive arithmetic
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 0, 0, "R3 rx light error");
    step(0, 0, 1, 1, 0, 0, 0, 0, "R3 rx heavy error");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R3 rx success");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R3 rx success");
    step(0, 0, 1, 0, 1, 0, 0, 0, "R3 rx error beats success");

    // R2 transmit arithmetic
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2 tx error");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2 tx error");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R2 tx success");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R2 tx error beats success");
    for (int i = 0; i < 24; i++) step(0, 1, 0, 0, 0, 0, 0, 0, "R2 tx decrement to floor");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R2 tx floor at zero");

    // R4 / R5 / R6 receive passive behaviour
    for (int i = 0; i < 15; i++) step(0, 0, 1, 1, 0, 0, 0, 0, "R4 rx climbs to passive");
    step(0, 0, 1, 1, 0, 0, 0, 0, "R5 heavy error frozen");
    step(0, 0, 1, 0, 0, 0, 0, 0, "R5 light error frozen");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R6 reload on success");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R3 decrement after reload");

    // R4 transmit passive, then R7 bus off
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R4 tx climbs to passive");
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R7 tx climbs to bus off");

    // R9 events ignored while bus off
    step(0, 1, 0, 0, 1, 0, 0, 0, "R9 successes ignored");
    step(1, 0, 1, 1, 0, 0, 0, 0, "R9 errors ignored");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R8 no tick no change");

    // R8 dominant bit breaks a run
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1, 1, 0, "R8 partial run");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R8 dominant restarts run");
    for (int i = 0; i < 11; i++) step(0, 0, 0, 0, 0, 1, 1, 0, "R8 full run counts one");

    // R8 / R10 remaining runs, with idle gaps inside some runs
    for (int r = 0; r < 127; r++) begin
      for (int b = 0; b < 11; b++) begin
        if (b == 5 && (r % 16) == 0) step(0, 0, 0, 0, 0, 0, 1, 0, "R8 gap cycle");
        step(0, 0, 0, 0, 0, 1, 1, 0, "R10 recovery runs");
      end
    end

    // R11 flag persistence and clear
    idle("R11 flag held");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R11 flag held under traffic");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R11 clear");
    step(0, 0, 1, 0, 0, 0, 0, 0, "R3 counting resumes after recovery");
    idle("R11 stays clear");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule